// File: doc/BRIEF.md
# Display Controller Self-Test Engine

This block runs the built-in self-test of an eight-character dot-matrix display controller. The host starts it by writing a 1 to the start bit of the control word. The engine first reads every address of the character-decoder ROM and forms an 8-bit running sum of the data. It compares that sum with a golden constant and records the result in a read-only pass bit. It then sends a checkerboard dot pattern, followed by the inverse checkerboard, to the LED drive logic as a valid/ready stream. In the last cycles of the test it writes a blank code into every character location, which also clears that location's flash bit. When the test ends, it clears the control word except for the pass bit and sets the user-character address register to all ones.

The test always takes exactly 2^TOTAL_LOG2 clock cycles. That is 262,144 cycles at the default setting. The ROM scan runs first. The last CHAR_N cycles are used for the blanking writes. The cycles in between are split evenly between the two patterns. The busy flag stays high for the whole span, and host writes to the control word are dropped while it is high.

The pattern stream follows the usual valid/ready rules. A beat is transferred on a clock edge where both `pat_valid` and `pat_ready` are high. While `pat_valid` is high and `pat_ready` is low, the beat's data, index and inverse flag do not change. There is one exception: because the test length is fixed, a beat that is still pending when the pattern window closes is withdrawn. `pat_ready` never changes the test timing.

Top module: `dsp_selftest`

## Requirements
- R1: After reset the control word reads 0x00, the user-character address reads 0, and busy, rom_rd, pat_valid and clr_we are all low.
- R2: A control-word write with bit 6 set while idle raises busy on the next edge. Busy then stays high for exactly 2^TOTAL_LOG2 cycles, and control-word bit 6 reads 1 whenever busy is high.
- R3: A control-word write while idle stores bits 7 and 4..0 as written. Bit 5 keeps its value whatever is written to it.
- R4: A control-word write while busy has no effect: it neither changes the stored bits nor restarts or lengthens the test.
- R5: In busy cycle k, for k below 2^ROM_AW, rom_rd is high and rom_addr equals k. In all other cycles rom_rd is low. ROM data is taken one cycle after the address.
- R6: Control-word bit 5 becomes 1 when the 8-bit wrapping sum of all ROM words equals SUM_GOLD, and 0 otherwise. It is updated once per test, right after the scan, and holds between tests.
- R7: Let HEAD = 2^TOTAL_LOG2 - 2*PAT_LEN - CHAR_N, where PAT_LEN = (2^TOTAL_LOG2 - 2^ROM_AW - 1 - CHAR_N)/2. Then pat_valid is high exactly in busy cycles HEAD+1 through 2^TOTAL_LOG2-CHAR_N-1. Dot bit r*COLS+c of pat_data is 1 when r+c is even and pat_inv is 0, and the reverse when pat_inv is 1.
- R8: Beats loaded in the first PAT_LEN cycles of the window have pat_inv 0, and later beats have pat_inv 1. pat_char counts 0, 1, ... CHAR_N-1 and wraps, advancing once per accepted beat and starting from 0 when the window opens.
- R9: While pat_valid is high and pat_ready is low, pat_data, pat_char and pat_inv hold on the next cycle, unless the window closes.
- R10: In the last CHAR_N busy cycles, clr_we is high, clr_addr counts 0 to CHAR_N-1 and clr_code is 0x20 (blank; the write also clears that location's flash bit). clr_we is low at all other times.
- R11: When busy falls, the control word reads only the pass bit (all other bits 0) and udc_addr reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_wr_en | input | 1 | Control-word write strobe |
| cw_wdata | input | 8 | Control-word write data |
| cw_rdata | output | 8 | Control-word readback (bit 6 start/busy, bit 5 pass) |
| busy | output | 1 | High during the whole self-test |
| rom_rd | output | 1 | Decoder ROM read enable |
| rom_addr | output | ROM_AW | Decoder ROM address |
| rom_rdata | input | 8 | Decoder ROM data, one cycle after the address |
| pat_valid | output | 1 | Pattern beat valid |
| pat_ready | input | 1 | Pattern beat accepted by the LED drive logic |
| pat_data | output | PAT_ROWS*PAT_COLS | Dot matrix of the beat, row-major |
| pat_char | output | clog2(CHAR_N) | Character position of the beat |
| pat_inv | output | 1 | Beat carries the inverse checkerboard |
| clr_we | output | 1 | Character location blanking write |
| clr_addr | output | clog2(CHAR_N) | Character location being blanked |
| clr_code | output | 8 | Code written, 0x20 during blanking |
| udc_addr | output | UDC_AW | User-character address register |

## Verification
The bench uses a 2^11-cycle test with a 32-word ROM model and tracks, cycle by cycle, where the ROM, pattern and blanking windows start and end. An off-by-one in the ROM data pipeline shows up as a wrong pass bit. So does a sum that drops the last word, and so does a run with one corrupted ROM word that still reports a pass.

Under random back-pressure, the bench looks for beats that change while stalled, a pat_char that skips or repeats, and an inverse flag that goes back to 0. A write in the middle of the test that changes the control word, or that restarts the test, shows up as a wrong busy length or a wrong readback. The bench also sweeps idle writes over all values with bit 6 clear, to catch a pass bit that writes can change.

// File: rtl/dsp_selftest_pkg.sv
package dsp_selftest_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ROM   = 3'd1,
    PH_PAT_A = 3'd2,
    PH_PAT_B = 3'd3,
    PH_WIPE  = 3'd4
  } phase_e;

  localparam int          CW_W       = 8;
  localparam int          START_BIT  = 6;
  localparam int          PASS_BIT   = 5;
  localparam logic [CW_W-1:0] PASS_MASK = CW_W'(1) << PASS_BIT;
  localparam logic [7:0]  BLANK_CODE = 8'h20;

endpackage

// File: rtl/dsp_selftest_seq.sv
module dsp_selftest_seq
  import dsp_selftest_pkg::*;
#(
  parameter int TL        = 18,
  parameter int HEAD      = 130,
  parameter int PAT_LEN   = 131003,
  parameter int WIPE_LEN  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [TL-1:0] cnt,
  output logic          last,
  output phase_e        phase
);

  localparam int TOTAL = 1 << TL;
  localparam logic [TL-1:0] PAT_A_AT = TL'(HEAD);
  localparam logic [TL-1:0] PAT_B_AT = TL'(HEAD + PAT_LEN);
  localparam logic [TL-1:0] WIPE_AT  = TL'(TOTAL - WIPE_LEN);

  assign last = busy && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  always_comb begin
    if (!busy)             phase = PH_IDLE;
    else if (cnt < PAT_A_AT) phase = PH_ROM;
    else if (cnt < PAT_B_AT) phase = PH_PAT_A;
    else if (cnt < WIPE_AT)  phase = PH_PAT_B;
    else                     phase = PH_WIPE;
  end

endmodule

// File: rtl/dsp_selftest_romsum.sv
module dsp_selftest_romsum
  import dsp_selftest_pkg::*;
#(
  parameter int         TL       = 18,
  parameter int         ROM_AW   = 7,
  parameter logic [7:0] SUM_GOLD = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  phase_e            phase,
  input  logic [TL-1:0]     cnt,
  output logic              rom_rd,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              pass_load,
  output logic              pass_val
);

  localparam int ROM_N = 1 << ROM_AW;
  localparam logic [TL-1:0] LAST_DATA_AT = TL'(ROM_N);

  logic       data_q;
  logic [7:0] sum_q;
  logic [7:0] sum_full;

  assign rom_rd   = (phase == PH_ROM) && (cnt < LAST_DATA_AT);
  assign rom_addr = cnt[ROM_AW-1:0];

  assign sum_full  = 8'(sum_q + rom_rdata);
  assign pass_load = data_q && (cnt == LAST_DATA_AT);
  assign pass_val  = (sum_full == SUM_GOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      sum_q  <= '0;
    end else begin
      data_q <= rom_rd;
      if (start)       sum_q <= '0;
      else if (data_q) sum_q <= sum_full;
    end
  end

endmodule

// File: rtl/dsp_selftest_patgen.sv
module dsp_selftest_patgen
  import dsp_selftest_pkg::*;
#(
  parameter int TL       = 18,
  parameter int CHAR_N   = 8,
  parameter int ROWS     = 7,
  parameter int COLS     = 5,
  parameter int WIPE_AT  = 262136
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  phase_e               phase,
  input  logic [TL-1:0]        cnt,
  output logic                 pat_valid,
  input  logic                 pat_ready,
  output logic [ROWS*COLS-1:0] pat_data,
  output logic [$clog2(CHAR_N > 1 ? CHAR_N : 2)-1:0] pat_char,
  output logic                 pat_inv
);

  localparam int PW  = ROWS * COLS;
  localparam int CAW = $clog2(CHAR_N > 1 ? CHAR_N : 2);
  localparam logic [TL-1:0]  CLOSE_AT = TL'(WIPE_AT - 1);
  localparam logic [CAW-1:0] IDX_TOP  = CAW'(CHAR_N - 1);

  logic [PW-1:0]  base_pat;
  logic [CAW-1:0] idx_q;
  logic           win;
  logic           inv_now;
  logic           load;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign base_pat[r*COLS + c] = ((r + c) % 2) == 0;
    end
  end

  assign win     = ((phase == PH_PAT_A) || (phase == PH_PAT_B)) && (cnt != CLOSE_AT);
  assign inv_now = (phase == PH_PAT_B);
  assign load    = win && (!pat_valid || pat_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_valid <= 1'b0;
      pat_data  <= '0;
      pat_char  <= '0;
      pat_inv   <= 1'b0;
      idx_q     <= '0;
    end else if (!win) begin
      pat_valid <= 1'b0;
      idx_q     <= '0;
    end else if (load) begin
      pat_valid <= 1'b1;
      pat_char  <= idx_q;
      pat_inv   <= inv_now;
      pat_data  <= inv_now ? ~base_pat : base_pat;
      idx_q     <= (idx_q == IDX_TOP) ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/dsp_selftest.sv
module dsp_selftest
  import dsp_selftest_pkg::*;
#(
  parameter int         TOTAL_LOG2 = 18,
  parameter int         ROM_AW     = 7,
  parameter int         CHAR_N     = 8,
  parameter int         PAT_ROWS   = 7,
  parameter int         PAT_COLS   = 5,
  parameter int         UDC_AW     = 4,
  parameter logic [7:0] SUM_GOLD   = 8'h00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cw_wr_en,
  input  logic [7:0]                   cw_wdata,
  output logic [7:0]                   cw_rdata,
  output logic                         busy,
  output logic                         rom_rd,
  output logic [ROM_AW-1:0]            rom_addr,
  input  logic [7:0]                   rom_rdata,
  output logic                         pat_valid,
  input  logic                         pat_ready,
  output logic [PAT_ROWS*PAT_COLS-1:0] pat_data,
  output logic [$clog2(CHAR_N > 1 ? CHAR_N : 2)-1:0] pat_char,
  output logic                         pat_inv,
  output logic                         clr_we,
  output logic [$clog2(CHAR_N > 1 ? CHAR_N : 2)-1:0] clr_addr,
  output logic [7:0]                   clr_code,
  output logic [UDC_AW-1:0]            udc_addr
);

  localparam int TL        = TOTAL_LOG2;
  localparam int TOTAL     = 1 << TL;
  localparam int PW        = PAT_ROWS * PAT_COLS;
  localparam int CAW       = $clog2(CHAR_N > 1 ? CHAR_N : 2);
  localparam int ROM_SPAN  = (1 << ROM_AW) + 1;
  localparam int WIPE_LEN  = CHAR_N;
  localparam int PAT_LEN   = (TOTAL - ROM_SPAN - WIPE_LEN) / 2;
  localparam int HEAD      = TOTAL - 2 * PAT_LEN - WIPE_LEN;
  localparam int WIPE_AT   = TOTAL - WIPE_LEN;
  localparam logic [TL-1:0] WIPE_START = TL'(WIPE_AT);

  logic          start;
  logic          seq_last;
  logic [TL-1:0] cnt;
  phase_e        phase;
  logic          pass_load;
  logic          pass_val;
  logic [7:0]    cw_q;

  assign start = cw_wr_en && !busy && cw_wdata[START_BIT];

  dsp_selftest_seq #(
    .TL       (TL),
    .HEAD     (HEAD),
    .PAT_LEN  (PAT_LEN),
    .WIPE_LEN (WIPE_LEN)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .cnt   (cnt),
    .last  (seq_last),
    .phase (phase)
  );

  dsp_selftest_romsum #(
    .TL       (TL),
    .ROM_AW   (ROM_AW),
    .SUM_GOLD (SUM_GOLD)
  ) u_romsum (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .phase     (phase),
    .cnt       (cnt),
    .rom_rd    (rom_rd),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_rdata),
    .pass_load (pass_load),
    .pass_val  (pass_val)
  );

  dsp_selftest_patgen #(
    .TL      (TL),
    .CHAR_N  (CHAR_N),
    .ROWS    (PAT_ROWS),
    .COLS    (PAT_COLS),
    .WIPE_AT (WIPE_AT)
  ) u_patgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .cnt       (cnt),
    .pat_valid (pat_valid),
    .pat_ready (pat_ready),
    .pat_data  (pat_data),
    .pat_char  (pat_char),
    .pat_inv   (pat_inv)
  );

  // Control word: bit 5 only moves on a pass result, the rest only while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_q <= '0;
    end else if (!busy) begin
      if (cw_wr_en) cw_q <= (cw_wdata & ~PASS_MASK) | (cw_q & PASS_MASK);
    end else if (seq_last) begin
      cw_q <= cw_q & PASS_MASK;
    end else if (pass_load) begin
      cw_q[PASS_BIT] <= pass_val;
    end
  end

  assign cw_rdata = cw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        udc_addr <= '0;
    else if (seq_last) udc_addr <= '1;
  end

  assign clr_we   = (phase == PH_WIPE);
  assign clr_addr = CAW'(cnt - WIPE_START);
  assign clr_code = clr_we ? BLANK_CODE : 8'h00;

endmodule

// File: rtl/dsp_selftest_chk.sv
module dsp_selftest_chk #(
  parameter int PW     = 35,
  parameter int CAW    = 3,
  parameter int UDC_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              seq_last,
  input logic              cw_wr_en,
  input logic [7:0]        cw_wdata,
  input logic [7:0]        cw_rdata,
  input logic              rom_rd,
  input logic              pat_valid,
  input logic              pat_ready,
  input logic [PW-1:0]     pat_data,
  input logic [CAW-1:0]    pat_char,
  input logic              pat_inv,
  input logic              clr_we,
  input logic [7:0]        clr_code,
  input logic [UDC_AW-1:0] udc_addr
);

  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cw_wr_en && cw_wdata[6]) |=> busy);

  // R2
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cw_rdata[6]);

  // R4
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_last) |=> (busy && {cw_rdata[7], cw_rdata[4:0]} == $past({cw_rdata[7], cw_rdata[4:0]})));

  // R5
  rom_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |-> busy);

  // R7
  pat_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> (busy && !clr_we && !rom_rd));

  // R9
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready) |=> (!pat_valid || ($stable(pat_data) && $stable(pat_char) && $stable(pat_inv))));

  // R10
  blank_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |-> (busy && clr_code == 8'h20));

  // R11
  end_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (((cw_rdata & 8'hDF) == 8'h00) && (udc_addr == '1)));

endmodule

bind dsp_selftest dsp_selftest_chk #(
  .PW     (PW),
  .CAW    (CAW),
  .UDC_AW (UDC_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .seq_last  (seq_last),
  .cw_wr_en  (cw_wr_en),
  .cw_wdata  (cw_wdata),
  .cw_rdata  (cw_rdata),
  .rom_rd    (rom_rd),
  .pat_valid (pat_valid),
  .pat_ready (pat_ready),
  .pat_data  (pat_data),
  .pat_char  (pat_char),
  .pat_inv   (pat_inv),
  .clr_we    (clr_we),
  .clr_code  (clr_code),
  .udc_addr  (udc_addr)
);

// File: tb/dsp_selftest_bench.sv
module dsp_selftest_bench;

  localparam int TL      = 11;
  localparam int RAW     = 5;
  localparam int NCH     = 8;
  localparam int ROWS    = 7;
  localparam int COLS    = 5;
  localparam int UAW     = 4;
  localparam int PW      = ROWS * COLS;
  localparam int CAW     = 3;
  localparam int ROM_N   = 1 << RAW;
  localparam int TOTAL   = 1 << TL;
  localparam int WIPE    = NCH;
  localparam int PAT_LEN = (TOTAL - ROM_N - 1 - WIPE) / 2;
  localparam int HEAD    = TOTAL - 2 * PAT_LEN - WIPE;

  function automatic logic [7:0] rom_f(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] gold_f();
    logic [7:0] s = 8'h00;
    for (int a = 0; a < ROM_N; a++) s = 8'(s + rom_f(a));
    return s;
  endfunction

  localparam logic [7:0] GOLD = gold_f();

  function automatic logic [PW-1:0] pat_f(logic inv);
    logic [PW-1:0] p;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        p[r*COLS + c] = (((r + c) % 2) == 0) ^ inv;
    return p;
  endfunction

  logic           clk;
  logic           rst_n;
  logic           cw_wr_en;
  logic [7:0]     cw_wdata;
  logic [7:0]     cw_rdata;
  logic           busy;
  logic           rom_rd;
  logic [RAW-1:0] rom_addr;
  logic [7:0]     rom_q;
  logic           pat_valid;
  logic           pat_ready;
  logic [PW-1:0]  pat_data;
  logic [CAW-1:0] pat_char;
  logic           pat_inv;
  logic           clr_we;
  logic [CAW-1:0] clr_addr;
  logic [7:0]     clr_code;
  logic [UAW-1:0] udc_addr;
  logic           bad_rom;

  int n_chk = 0;
  int n_err = 0;

  dsp_selftest #(
    .TOTAL_LOG2 (TL),
    .ROM_AW     (RAW),
    .CHAR_N     (NCH),
    .PAT_ROWS   (ROWS),
    .PAT_COLS   (COLS),
    .UDC_AW     (UAW),
    .SUM_GOLD   (GOLD)
  ) u_dsp_selftest (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_wr_en  (cw_wr_en),
    .cw_wdata  (cw_wdata),
    .cw_rdata  (cw_rdata),
    .busy      (busy),
    .rom_rd    (rom_rd),
    .rom_addr  (rom_addr),
    .rom_rdata (rom_q),
    .pat_valid (pat_valid),
    .pat_ready (pat_ready),
    .pat_data  (pat_data),
    .pat_char  (pat_char),
    .pat_inv   (pat_inv),
    .clr_we    (clr_we),
    .clr_addr  (clr_addr),
    .clr_code  (clr_code),
    .udc_addr  (udc_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ROM model: one cycle read latency, optional single-bit fault at word 3
  always_ff @(posedge clk) begin
    if (rom_rd)
      rom_q <= rom_f(int'(rom_addr)) ^ ((bad_rom && rom_addr == RAW'(3)) ? 8'h01 : 8'h00);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cw_write(input logic [7:0] v);
    @(negedge clk);
    cw_wr_en = 1'b1;
    cw_wdata = v;
    @(negedge clk);
    cw_wr_en = 1'b0;
  endtask

  task automatic run_test(input bit bad, input bit bp);
    logic [15:0]    lfsr = 16'hACE1;
    logic           pend = 1'b0;
    logic [PW-1:0]  p_data = '0;
    logic [CAW-1:0] p_char = '0;
    logic           p_inv = 1'b0;
    int             exp_idx = 0;
    logic           seen_inv = 1'b0;
    int             n_inv0 = 0;
    int             n_inv1 = 0;
    logic           exp_pass = !bad;
    logic           v_exp;
    bad_rom = bad;
    @(negedge clk);
    cw_wr_en = 1'b1;
    cw_wdata = 8'h40;
    pat_ready = 1'b1;
    for (int k = 0; k < TOTAL; k++) begin
      @(negedge clk);
      if (k == 0) cw_wr_en = 1'b0;
      chk(busy == 1'b1, "R2", "busy during test", busy, 1);
      chk(cw_rdata[6] == 1'b1, "R2", "bit6 during test", cw_rdata, 8'h40);
      // ROM scan
      chk(rom_rd == (k < ROM_N), "R5", "rom_rd", rom_rd, (k < ROM_N));
      if (k < ROM_N) chk(rom_addr == RAW'(k), "R5", "rom_addr", rom_addr, k);
      if (k == ROM_N + 1)
        chk(cw_rdata[5] == exp_pass, "R6", "pass bit after scan", cw_rdata[5], exp_pass);
      // mid-test writes are dropped
      if (k == 100) begin cw_wr_en = 1'b1; cw_wdata = 8'h9F; end
      if (k == 101) begin
        cw_wr_en = 1'b0;
        chk(cw_rdata == (8'h40 | {2'b00, exp_pass, 5'b0}), "R4", "cw after busy write",
            cw_rdata, 8'h40 | {2'b00, exp_pass, 5'b0});
      end
      if (k == 200) begin cw_wr_en = 1'b1; cw_wdata = 8'h40; end
      if (k == 201) cw_wr_en = 1'b0;
      // blanking writes
      chk(clr_we == (k >= TOTAL - WIPE), "R10", "clr_we", clr_we, (k >= TOTAL - WIPE));
      if (k >= TOTAL - WIPE) begin
        chk(clr_addr == CAW'(k - (TOTAL - WIPE)), "R10", "clr_addr", clr_addr, k - (TOTAL - WIPE));
        chk(clr_code == 8'h20, "R10", "clr_code", clr_code, 8'h20);
      end
      // pattern stream
      v_exp = (k >= HEAD + 1) && (k <= TOTAL - WIPE - 1);
      chk(pat_valid == v_exp, "R7", "pat_valid window", pat_valid, v_exp);
      if (k == HEAD + 1) exp_idx = 0;
      if (pat_valid) begin
        chk(pat_data == pat_f(pat_inv), "R7", "dot pattern", pat_data, pat_f(pat_inv));
        if (pend) begin
          chk(pat_data == p_data && pat_char == p_char && pat_inv == p_inv, "R9",
              "stalled beat held", {pat_inv, pat_char}, {p_inv, p_char});
        end
        if (!bp) begin
          chk(pat_inv == ((k - 1) >= HEAD + PAT_LEN), "R8", "inverse flag timing",
              pat_inv, ((k - 1) >= HEAD + PAT_LEN));
          chk(pat_char == CAW'((k - 1 - HEAD) % NCH), "R8", "char index timing",
              pat_char, (k - 1 - HEAD) % NCH);
        end
      end
      // choose ready for the coming edge
      if (bp) begin
        pat_ready = lfsr[0] | lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end else begin
        pat_ready = 1'b1;
      end
      if (pat_valid && pat_ready) begin
        chk(pat_char == CAW'(exp_idx), "R8", "accepted char order", pat_char, exp_idx);
        exp_idx = (exp_idx + 1) % NCH;
        chk(!(seen_inv && !pat_inv), "R8", "inverse never returns to normal", pat_inv, 1);
        if (pat_inv) begin seen_inv = 1'b1; n_inv1++; end
        else n_inv0++;
      end
      pend   = pat_valid && !pat_ready;
      p_data = pat_data;
      p_char = pat_char;
      p_inv  = pat_inv;
    end
    @(negedge clk);
    chk(busy == 1'b0, "R2", "busy length exact", busy, 0);
    chk(n_inv0 > 0 && n_inv1 > 0, "R8", "both patterns delivered", n_inv0 * 65536 + n_inv1, 1);
    chk(cw_rdata == {2'b00, exp_pass, 5'b0}, "R11", "cw at end", cw_rdata, {2'b00, exp_pass, 5'b0});
    chk(udc_addr == '1, "R11", "udc_addr at end", udc_addr, 4'hF);
    chk(pat_valid == 1'b0 && clr_we == 1'b0 && rom_rd == 1'b0, "R10", "outputs quiet after test",
        {pat_valid, clr_we, rom_rd}, 0);
    pat_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cw_wr_en = 1'b0;
    cw_wdata = 8'h00;
    pat_ready = 1'b0;
    bad_rom = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cw_rdata == 8'h00, "R1", "cw reset", cw_rdata, 0);
    chk(busy == 1'b0, "R1", "busy reset", busy, 0);
    chk(rom_rd == 1'b0 && pat_valid == 1'b0 && clr_we == 1'b0, "R1", "strobes reset",
        {rom_rd, pat_valid, clr_we}, 0);
    chk(udc_addr == '0, "R1", "udc reset", udc_addr, 0);
    rst_n = 1'b1;

    // R3 sweep of idle writes without the start bit
    for (int v = 0; v < 256; v++) begin
      if (v[6] == 1'b0) begin
        cw_write(8'(v));
        chk(cw_rdata == (8'(v) & 8'hDF), "R3", "idle write store", cw_rdata, v & 8'hDF);
        chk(busy == 1'b0, "R3", "no start without bit6", busy, 0);
      end
    end
    cw_write(8'h00);

    run_test(1'b0, 1'b0);
    cw_write(8'h1F);
    chk(cw_rdata == 8'h3F, "R6", "pass bit sticky over write", cw_rdata, 8'h3F);
    cw_write(8'h00);
    chk(cw_rdata == 8'h20, "R3", "bit5 not writable", cw_rdata, 8'h20);

    run_test(1'b0, 1'b1);
    run_test(1'b1, 1'b1);
    cw_write(8'hBF);
    chk(cw_rdata == 8'h9F, "R6", "fail bit holds over write", cw_rdata, 8'h9F);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule